// File: doc/BRIEF.md
# Row Waveform Select Shifter

This block produces the per-row select codes that steer an image sensor's overflow-gate drive. It is a chain of stages, one per pixel row, each holding a one-hot word as wide as the number of external voltage lines. The bit that is set in a row's stage picks which voltage line drives that row. An advance strobe moves every word one stage toward the last row and takes in a new word at the head. A sequence of words fed in at the head therefore appears at each row as a stepped waveform. Each row lags the row before it by one advance, which is what a progressive-scan readout needs.

A head word that does not have exactly one bit set is refused. The first stage takes all-zero instead, so that row selects no line, and a sticky error flag rises and stays high until reset. Each row also gets a binary-encoded copy of its select code. The analog switches and the pixel array sit outside this block.

Top module: `rowwave_shifter`

## Requirements
- R1: After reset every stage is all-zero, so no row selects a line, every binary index reads 0, and the error flag is low.
- R2: When `step` is high and `head_word` has exactly one bit set, stage 0 (row 0, bits [SEL_W-1:0] of `row_sel`) holds that word after the clock edge.
- R3: When `step` is high, stage r takes the old value of stage r-1 for every r from 1 to NUM_ROWS-1. The old value of the last stage is dropped.
- R4: When `step` is low, every stage holds its value, whatever is on `head_word`.
- R5: When `step` is high and `head_word` is zero or has two or more bits set, stage 0 becomes all-zero. The other stages still shift as in R3.
- R6: `bad_word` goes high on the edge after an R5 event and stays high until reset. A malformed head word while `step` is low does not set it.
- R7: Every stage is always either all-zero or has exactly one bit set.
- R8: `row_idx` for row r (bits [r*IDX_W +: IDX_W], IDX_W = clog2(SEL_W)) is the position of the set bit in that row's stage, counted from bit 0. It is 0 when the stage is all-zero.
- R9: A word entered on advance k shows up at row r after advance k+r. After that many advances each row reproduces the head sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Advance strobe: shift the chain and load the head word |
| head_word | input | SEL_W | Word entered at the head, expected one-hot |
| row_sel | output | NUM_ROWS*SEL_W | One-hot line select per row, row r at [r*SEL_W +: SEL_W] |
| row_idx | output | NUM_ROWS*IDX_W | Binary index of each row's selected line |
| bad_word | output | 1 | Sticky flag for a refused head word |

## Verification
A four-row instance first receives a ramp of one-hot words, one per line position. Comparing every row after every advance tells whether the shift is correct, whether the skew is one advance per row, and whether the binary index is encoded correctly. All 256 eight-bit head words are then entered in turn. This sweep separates accepted words from refused ones: it catches a validity check that lets through zero or multi-bit words, and one that wrongly rejects good words. Hold cycles with changing head words, including malformed ones while the strobe is low, show whether the chain stays frozen and whether the error flag is set only by a real refusal.

// File: rtl/rowwave_pkg.sv
// Package: shared helpers for the row waveform select shifter.
// Assumes select words of any width up to 32 bits.
package rowwave_pkg;

    // Returns 1 when exactly one bit of w is set (w given as 32 bits).
    function automatic logic word_is_onehot(input logic [31:0] w);
        int unsigned n;
        n = 0;
        for (int k = 0; k < 32; k++) begin
            n = n + 32'(w[k]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/rowwave_head_gate.sv
// Head gate: passes the head word through when it is one-hot, otherwise
// passes all-zero and raises a refusal strobe. Assumes SEL_W <= 32.
module rowwave_head_gate #(
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] word_in,
    output logic [SEL_W-1:0] word_out,
    output logic             refuse
);
    import rowwave_pkg::*;

    logic ok;

    // Decide whether the head word is acceptable and filter it.
    always_comb begin
        ok       = word_is_onehot(32'(word_in));
        word_out = ok ? word_in : '0;
        refuse   = !ok;
    end
endmodule

// File: rtl/rowwave_encoder.sv
// One-hot to binary encoder. Assumes the input is zero or one-hot; zero
// encodes to 0.
module rowwave_encoder #(
    parameter int SEL_W = 8,
    localparam int IDX_W = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
    input  logic [SEL_W-1:0] onehot,
    output logic [IDX_W-1:0] index
);
    // OR together the positions of all set bits.
    always_comb begin
        index = '0;
        for (int k = 0; k < SEL_W; k++) begin
            if (onehot[k]) index = index | IDX_W'(k);
        end
    end
endmodule

// File: rtl/rowwave_stage.sv
// One row stage: a register that loads its upstream word on an advance,
// plus a binary index of its contents. Synchronous active-low reset to zero.
module rowwave_stage #(
    parameter int SEL_W = 8,
    localparam int IDX_W = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SEL_W-1:0] d,
    output logic [SEL_W-1:0] q,
    output logic [IDX_W-1:0] idx
);
    // Hold the row's select word; take the upstream word on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (step) q <= d;
    end

    rowwave_encoder #(.SEL_W(SEL_W)) i_enc (
        .onehot (q),
        .index  (idx)
    );
endmodule

// File: rtl/rowwave_shifter.sv
// Top: chain of NUM_ROWS stages producing one-hot voltage-line selects per
// row, with head-word validation and a sticky refusal flag.
// Assumes the caller strobes step once per waveform time step.
module rowwave_shifter #(
    parameter int NUM_ROWS = 256,
    parameter int SEL_W    = 8,
    localparam int IDX_W   = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step,
    input  logic [SEL_W-1:0]          head_word,
    output logic [NUM_ROWS*SEL_W-1:0] row_sel,
    output logic [NUM_ROWS*IDX_W-1:0] row_idx,
    output logic                      bad_word
);
    logic [SEL_W-1:0] head_ok;
    logic             head_refuse;
    logic [SEL_W-1:0] chain [NUM_ROWS+1];

    rowwave_head_gate #(.SEL_W(SEL_W)) i_gate (
        .word_in  (head_word),
        .word_out (head_ok),
        .refuse   (head_refuse)
    );

    assign chain[0] = head_ok;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        logic [IDX_W-1:0] idx_r;
        rowwave_stage #(.SEL_W(SEL_W)) i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .d     (chain[r]),
            .q     (chain[r+1]),
            .idx   (idx_r)
        );
        assign row_sel[r*SEL_W +: SEL_W] = chain[r+1];
        assign row_idx[r*IDX_W +: IDX_W] = idx_r;
    end

    // Sticky flag: set by a refused head word on an advance, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bad_word <= 1'b0;
        else if (step && head_refuse) bad_word <= 1'b1;
    end
endmodule

// File: rtl/rowwave_shifter_chk.sv
// Checker for rowwave_shifter: temporal properties over its ports only.
module rowwave_shifter_chk #(
    parameter int NUM_ROWS = 256,
    parameter int SEL_W    = 8,
    localparam int IDX_W   = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      step,
    input logic [SEL_W-1:0]          head_word,
    input logic [NUM_ROWS*SEL_W-1:0] row_sel,
    input logic [NUM_ROWS*IDX_W-1:0] row_idx,
    input logic                      bad_word
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (row_sel == '0) && (row_idx == '0) && !bad_word);

    // R2
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $onehot(head_word)) |=> row_sel[SEL_W-1:0] == $past(head_word));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_sel));

    // R5
    refuse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !$onehot(head_word)) |=> row_sel[SEL_W-1:0] == '0);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !$onehot(head_word)) |=> bad_word);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_word |=> bad_word);

    // R7
    row0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel[SEL_W-1:0]));

    // R7
    last_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel[NUM_ROWS*SEL_W-1 -: SEL_W]));

    // R8
    row0_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel[SEL_W-1:0] != '0) |->
            row_sel[SEL_W-1:0] == (SEL_W'(1) << row_idx[IDX_W-1:0]));

    generate
        if (NUM_ROWS > 1) begin : g_shift
            // R3
            shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> row_sel[NUM_ROWS*SEL_W-1:SEL_W]
                         == $past(row_sel[(NUM_ROWS-1)*SEL_W-1:0]));
        end
    endgenerate
endmodule

bind rowwave_shifter rowwave_shifter_chk #(
    .NUM_ROWS (NUM_ROWS),
    .SEL_W    (SEL_W)
) i_rowwave_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .head_word (head_word),
    .row_sel   (row_sel),
    .row_idx   (row_idx),
    .bad_word  (bad_word)
);

// File: tb/test_rowwave_shifter.sv
// Bench: small four-row instance, reference model computed arithmetically.
module test_rowwave_shifter;
    localparam int NR = 4;
    localparam int SW = 8;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step = 1'b0;
    logic [SW-1:0]     head_word = '0;
    logic [NR*SW-1:0]  row_sel;
    logic [NR*IW-1:0]  row_idx;
    logic              bad_word;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [SW-1:0] mdl [NR];
    logic          mflag;

    rowwave_shifter #(.NUM_ROWS(NR), .SEL_W(SW)) i_rowwave_shifter (
        .clk(clk), .rst_n(rst_n), .step(step), .head_word(head_word),
        .row_sel(row_sel), .row_idx(row_idx), .bad_word(bad_word)
    );

    always #4 clk = ~clk;

    function automatic bit is_oh(input logic [SW-1:0] w);
        return (w != 0) && ((w & (w - 1'b1)) == 0);
    endfunction

    // Compare every row and the flag against the model (one check each).
    task automatic check_all(input string req);
        for (int r = 0; r < NR; r++) begin
            logic [IW-1:0] eidx;
            eidx = (mdl[r] == 0) ? '0 : IW'($clog2(mdl[r]));
            tests++;
            if (row_sel[r*SW +: SW] !== mdl[r] || row_idx[r*IW +: IW] !== eidx) begin
                fails++;
                $display("FAIL %s row %0d: sel=%h idx=%0d expected sel=%h idx=%0d",
                         req, r, row_sel[r*SW +: SW], row_idx[r*IW +: IW], mdl[r], eidx);
            end
        end
        tests++;
        if (bad_word !== mflag) begin
            fails++;
            $display("FAIL %s flag: got %b expected %b", req, bad_word, mflag);
        end
    endtask

    // Apply one cycle of inputs at the falling edge; update the model after it.
    task automatic cycle(input logic s, input logic [SW-1:0] w);
        @(negedge clk);
        step = s;
        head_word = w;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            for (int r = 0; r < NR; r++) mdl[r] = '0;
            mflag = 1'b0;
        end else if (s) begin
            for (int r = NR - 1; r > 0; r--) mdl[r] = mdl[r-1];
            mdl[0] = is_oh(w) ? w : '0;
            if (!is_oh(w)) mflag = 1'b1;
        end
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cycle(1'b0, '0);
        cycle(1'b0, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int r = 0; r < NR; r++) mdl[r] = 8'hA5;
        mflag = 1'b1;
        // R1: reset state
        do_reset();
        check_all("R1");

        // R2 R3 R8 R9: ramp of one-hot words, check skew after each advance
        for (int k = 0; k < SW + NR; k++) begin
            cycle(1'b1, SW'(1) << (k % SW));
            check_all("R2/R3/R8/R9");
        end

        // R4: hold with varied head words, including malformed ones (R6)
        for (int k = 0; k < 8; k++) begin
            cycle(1'b0, 8'(k * 37 + 3));
            check_all("R4/R6");
        end

        // R5 R6 R7: exhaustive sweep of every 8-bit head word
        for (int w = 0; w < 256; w++) begin
            cycle(1'b1, 8'(w));
            check_all("R5/R6/R7");
        end

        // R1: reset clears the sticky flag and chain
        do_reset();
        check_all("R1");

        // R6: malformed word with step low leaves flag low
        cycle(1'b0, 8'hFF);
        check_all("R6");

        // R5: zero word refused mid-stream, others keep shifting
        cycle(1'b1, 8'h10);
        cycle(1'b1, 8'h00);
        cycle(1'b1, 8'h02);
        check_all("R5/R3");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule